// File: doc/BRIEF.md
# Flag-Producing Subtractor with Conditional Branch Test

This block is the status-flag end of a small integer datapath. Each cycle it may take two operands and an operation code. It runs an add, a subtract, a compare, a bitwise AND or a bit test, and stores four status flags: carry, sign, zero and overflow. Add, subtract and AND also deliver their result on a registered output. Compare and test change only the flags, so the last delivered result stays in place. A no-operation code leaves all stored state as it is.

Alongside, a branch evaluator reads a 5-bit condition code in the same cycle and tests it against the stored flags. The output is a single take-branch bit. The codes cover the eight single-flag tests, six unsigned magnitude tests and six signed magnitude tests. The magnitude tests give the relation between A and B once a compare of A and B has set the flags. Program-counter update is left to the surrounding logic.

Top module: `alu_branch_unit`

## Requirements
- R1: Operation codes on `op_i` are 0 no-op, 1 add, 2 subtract, 3 compare, 4 AND, 5 test; codes 6 and 7 behave as no-op. The result and flags update on the rising clock edge at which the code is presented, and become visible after that edge.
- R2: Subtract delivers A + ~B + 1 modulo 2^W. The carry flag is the carry out of the top bit, so carry = 1 means no borrow (A >= B unsigned).
- R3: Add delivers A + B modulo 2^W, with the carry flag equal to the carry out of the top bit.
- R4: After any flag-setting operation, sign equals the top bit of the computed value and zero is 1 exactly when all W bits of it are 0.
- R5: After add, subtract or compare, overflow is the XOR of the carry into the top bit and the carry out of it. This equals signed overflow of the operation.
- R6: AND and test compute A AND B bitwise and clear carry and overflow.
- R7: Compare sets flags exactly as subtract does, and test exactly as AND does, but neither changes `res_o`.
- R8: No-op (and codes 6, 7) leaves `res_o` and all four flags unchanged.
- R9: Single-flag conditions: code 0 zero=1, 1 zero=0, 2 carry=1, 3 carry=0, 4 sign=0, 5 sign=1, 6 overflow=1, 7 overflow=0.
- R10: Unsigned conditions after compare: 8 higher (C & ~Z), 9 higher-or-equal (C), 10 lower (~C), 11 lower-or-equal (~C | Z), 12 equal (Z), 13 not-equal (~Z).
- R11: Signed conditions after compare: 16 greater (~(S^V) & ~Z), 17 greater-or-equal (~(S^V)), 18 less (S^V), 19 less-or-equal ((S^V) | Z), 20 equal (Z), 21 not-equal (~Z).
- R12: Condition codes 14, 15 and 22 to 31 give take-branch 0 whatever the flags.
- R13: `take_o` is combinational from `cond_i` and the stored flags. A change of `cond_i` is reflected in the same cycle.
- R14: While reset is active, `res_o` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| cond_i | input | 5 | Branch condition code |
| res_o | output | W | Last delivered result |
| c_o | output | 1 | Carry flag |
| s_o | output | 1 | Sign flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| take_o | output | 1 | Take-branch decision |

## Verification
A wrong carry into the top bit would show first as a wrong overflow flag. It appears one edge after a subtract or add whose operands have signs such that overflow is possible. It then shows in every signed condition read from those flags in the following cycles. A wrong stored flag cannot hide: the bench sweeps all 32 condition codes over held flags, so a single bad flag bit changes `take_o` in the same cycle for several codes. A compare or test that wrongly writes `res_o` appears one edge after the operation as a changed result.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int OP_W   = 3;
  localparam int COND_W = 5;
  localparam int NCOND  = 1 << COND_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_CMP = 3'd3,
    OP_AND = 3'd4,
    OP_TST = 3'd5
  } op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  // condition codes
  localparam logic [COND_W-1:0] CC_ZS  = 5'd0;
  localparam logic [COND_W-1:0] CC_ZC  = 5'd1;
  localparam logic [COND_W-1:0] CC_CS  = 5'd2;
  localparam logic [COND_W-1:0] CC_CC  = 5'd3;
  localparam logic [COND_W-1:0] CC_PL  = 5'd4;
  localparam logic [COND_W-1:0] CC_MI  = 5'd5;
  localparam logic [COND_W-1:0] CC_VS  = 5'd6;
  localparam logic [COND_W-1:0] CC_VC  = 5'd7;
  localparam logic [COND_W-1:0] CC_UHI = 5'd8;
  localparam logic [COND_W-1:0] CC_UHE = 5'd9;
  localparam logic [COND_W-1:0] CC_ULO = 5'd10;
  localparam logic [COND_W-1:0] CC_ULE = 5'd11;
  localparam logic [COND_W-1:0] CC_UEQ = 5'd12;
  localparam logic [COND_W-1:0] CC_UNE = 5'd13;
  localparam logic [COND_W-1:0] CC_SGT = 5'd16;
  localparam logic [COND_W-1:0] CC_SGE = 5'd17;
  localparam logic [COND_W-1:0] CC_SLT = 5'd18;
  localparam logic [COND_W-1:0] CC_SLE = 5'd19;
  localparam logic [COND_W-1:0] CC_SEQ = 5'd20;
  localparam logic [COND_W-1:0] CC_SNE = 5'd21;

  // Decision for one condition code against a flag set.
  function automatic logic cond_hit(input logic [COND_W-1:0] code, input flags_t f);
    logic lt;
    lt = f.s ^ f.v;
    case (code)
      CC_ZS:  cond_hit = f.z;
      CC_ZC:  cond_hit = ~f.z;
      CC_CS:  cond_hit = f.c;
      CC_CC:  cond_hit = ~f.c;
      CC_PL:  cond_hit = ~f.s;
      CC_MI:  cond_hit = f.s;
      CC_VS:  cond_hit = f.v;
      CC_VC:  cond_hit = ~f.v;
      CC_UHI: cond_hit = f.c & ~f.z;
      CC_UHE: cond_hit = f.c;
      CC_ULO: cond_hit = ~f.c;
      CC_ULE: cond_hit = ~f.c | f.z;
      CC_UEQ: cond_hit = f.z;
      CC_UNE: cond_hit = ~f.z;
      CC_SGT: cond_hit = ~lt & ~f.z;
      CC_SGE: cond_hit = ~lt;
      CC_SLT: cond_hit = lt;
      CC_SLE: cond_hit = lt | f.z;
      CC_SEQ: cond_hit = f.z;
      CC_SNE: cond_hit = ~f.z;
      default: cond_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    value,
  output logic            carry_top_in,
  output logic            carry_top_out,
  output logic            is_logic,
  output logic            writes_flags,
  output logic            writes_result
);

  localparam int LOW_W = W - 1;

  // Sum of the low W-1 bits; its top bit is the carry into the MSB.
  function automatic logic [LOW_W:0] low_sum(input logic [LOW_W-1:0] x,
                                             input logic [LOW_W-1:0] y,
                                             input logic cin);
    low_sum = {1'b0, x} + {1'b0, y} + {{LOW_W{1'b0}}, cin};
  endfunction

  // One-bit full add of the MSB column.
  function automatic logic [1:0] top_sum(input logic x, input logic y, input logic cin);
    top_sum = {1'b0, x} + {1'b0, y} + {1'b0, cin};
  endfunction

  logic            is_sub;
  logic [W-1:0]    b_eff;
  logic [LOW_W:0]  lo;
  logic [1:0]      hi;

  always_comb begin
    is_sub        = (op == OP_SUB) || (op == OP_CMP);
    is_logic      = (op == OP_AND) || (op == OP_TST);
    writes_flags  = is_sub || is_logic || (op == OP_ADD);
    writes_result = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
    b_eff         = is_sub ? ~b : b;
    lo            = low_sum(a[LOW_W-1:0], b_eff[LOW_W-1:0], is_sub);
    hi            = top_sum(a[W-1], b_eff[W-1], lo[LOW_W]);
    if (is_logic) begin
      value         = a & b;
      carry_top_in  = 1'b0;
      carry_top_out = 1'b0;
    end else begin
      value         = {hi[0], lo[LOW_W-1:0]};
      carry_top_in  = lo[LOW_W];
      carry_top_out = hi[1];
    end
  end

endmodule

// File: rtl/alu_flag_store.sv
module alu_flag_store
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] value,
  input  logic         carry_top_in,
  input  logic         carry_top_out,
  input  logic         is_logic,
  input  logic         writes_flags,
  input  logic         writes_result,
  output logic [W-1:0] res_q,
  output flags_t       flags_q
);

  flags_t flags_d;

  always_comb begin
    flags_d.c = carry_top_out;
    flags_d.s = value[W-1];
    flags_d.z = (value == '0);
    flags_d.v = is_logic ? 1'b0 : (carry_top_in ^ carry_top_out);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      if (writes_result) res_q <= value;
      if (writes_flags)  flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/alu_branch_eval.sv
module alu_branch_eval
  import alu_flag_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  flags_t            flags,
  output logic              take
);

  logic [NCOND-1:0] hit;

  for (genvar k = 0; k < NCOND; k++) begin : g_cond
    assign hit[k] = cond_hit(COND_W'(k), flags);
  end

  assign take = hit[cond];

endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [W-1:0]      res_o,
  output logic              c_o,
  output logic              s_o,
  output logic              z_o,
  output logic              v_o,
  output logic              take_o
);

  logic [W-1:0] core_value;
  logic         core_cin_top;
  logic         core_cout_top;
  logic         core_logic;
  logic         core_wflags;
  logic         core_wres;
  flags_t       flags_q;

  alu_arith_core #(.W(W)) u_core (
    .op            (op_i),
    .a             (a_i),
    .b             (b_i),
    .value         (core_value),
    .carry_top_in  (core_cin_top),
    .carry_top_out (core_cout_top),
    .is_logic      (core_logic),
    .writes_flags  (core_wflags),
    .writes_result (core_wres)
  );

  alu_flag_store #(.W(W)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .value         (core_value),
    .carry_top_in  (core_cin_top),
    .carry_top_out (core_cout_top),
    .is_logic      (core_logic),
    .writes_flags  (core_wflags),
    .writes_result (core_wres),
    .res_q         (res_o),
    .flags_q       (flags_q)
  );

  alu_branch_eval u_eval (
    .cond  (cond_i),
    .flags (flags_q),
    .take  (take_o)
  );

  assign c_o = flags_q.c;
  assign s_o = flags_q.s;
  assign z_o = flags_q.z;
  assign v_o = flags_q.v;

endmodule

// File: rtl/alu_branch_unit_chk.sv
module alu_branch_unit_chk
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_i,
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic [COND_W-1:0] cond_i,
  input logic [W-1:0]      res_o,
  input logic              c_o,
  input logic              s_o,
  input logic              z_o,
  input logic              v_o,
  input logic              take_o,
  input logic [W-1:0]      core_value
);

  logic sets_flags;
  logic is_arith_sub;
  logic holds_all;
  assign sets_flags   = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_CMP) ||
                        (op_i == OP_AND) || (op_i == OP_TST);
  assign is_arith_sub = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign holds_all    = !sets_flags;

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sets_flags |=> (z_o == ($past(core_value) == '0)));

  // R4
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sets_flags |=> (s_o == $past(core_value[W-1])));

  // R5
  sub_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_arith_sub |=> (v_o == (($past(a_i[W-1]) != $past(b_i[W-1])) &&
                              ($past(core_value[W-1]) != $past(a_i[W-1])))));

  // R5
  add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD) |=> (v_o == (($past(a_i[W-1]) == $past(b_i[W-1])) &&
                                  ($past(core_value[W-1]) != $past(a_i[W-1])))));

  // R6
  logic_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_AND) || (op_i == OP_TST)) |=> (!c_o && !v_o));

  // R7
  compare_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_CMP) || (op_i == OP_TST)) |=> $stable(res_o));

  // R8
  nop_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holds_all |=> ($stable(res_o) && $stable({c_o, s_o, z_o, v_o})));

  // R12
  unused_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond_i == 5'd14) || (cond_i == 5'd15) || (cond_i >= 5'd22)) |-> !take_o);

  // R10
  equal_follows_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond_i == CC_UEQ) || (cond_i == CC_SEQ)) |-> (take_o == z_o));

endmodule

bind alu_branch_unit alu_branch_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_i       (op_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .cond_i     (cond_i),
  .res_o      (res_o),
  .c_o        (c_o),
  .s_o        (s_o),
  .z_o        (z_o),
  .v_o        (v_o),
  .take_o     (take_o),
  .core_value (core_value)
);

// File: tb/alu_branch_unit_bench.sv
module alu_branch_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [7:0] a_i = 8'd0;
  logic [7:0] b_i = 8'd0;
  logic [4:0] cond_i = 5'd0;
  logic [7:0] res_o;
  logic       c_o, s_o, z_o, v_o, take_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int m_res, m_c, m_s, m_z, m_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_branch_unit #(.W(W)) u_alu_branch_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .cond_i(cond_i),
    .res_o(res_o), .c_o(c_o), .s_o(s_o), .z_o(z_o), .v_o(v_o), .take_o(take_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int m_take(input int code);
    case (code)
      0: return m_z;        1: return 1 - m_z;
      2: return m_c;        3: return 1 - m_c;
      4: return 1 - m_s;    5: return m_s;
      6: return m_v;        7: return 1 - m_v;
      8: return (m_c == 1 && m_z == 0) ? 1 : 0;
      9: return m_c;
      10: return 1 - m_c;
      11: return (m_c == 0 || m_z == 1) ? 1 : 0;
      12, 20: return m_z;
      13, 21: return 1 - m_z;
      16: return (m_s == m_v && m_z == 0) ? 1 : 0;
      17: return (m_s == m_v) ? 1 : 0;
      18: return (m_s != m_v) ? 1 : 0;
      19: return (m_s != m_v || m_z == 1) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(input int code);
    if (code < 8) return "R9";
    if (code < 14) return "R10";
    if (code >= 16 && code < 22) return "R11";
    return "R12";
  endfunction

  // Reference update for one operation.
  task automatic model_op(input int op, input int a, input int b);
    int full, r, sv;
    case (op)
      1: begin
        full = a + b; r = full % 256;
        sv = sx(a) + sx(b);
        m_c = (full > 255) ? 1 : 0; m_v = (sv > 127 || sv < -128) ? 1 : 0;
        m_res = r;
      end
      2, 3: begin
        full = a + (255 - b) + 1; r = full % 256;
        sv = sx(a) - sx(b);
        m_c = (full > 255) ? 1 : 0; m_v = (sv > 127 || sv < -128) ? 1 : 0;
        if (op == 2) m_res = r;
      end
      4, 5: begin
        r = a & b; m_c = 0; m_v = 0;
        if (op == 4) m_res = r;
      end
      default: return;
    endcase
    m_s = (r >= 128) ? 1 : 0;
    m_z = (r == 0) ? 1 : 0;
  endtask

  task automatic compare_all(input string tag, input int cond);
    check(res_o == m_res[7:0], {tag, " result"}, res_o, m_res);
    check({c_o, s_o, z_o, v_o} == {m_c[0], m_s[0], m_z[0], m_v[0]}, {tag, " flags"},
          {c_o, s_o, z_o, v_o}, {m_c[0], m_s[0], m_z[0], m_v[0]});
    check(take_o == m_take(cond), {req_of(cond), " take"}, take_o, m_take(cond));
  endtask

  // One cycle: drive at negedge, update model at edge, check at next negedge.
  task automatic step(input int op, input int a, input int b, input int cond, input string tag);
    op_i = op[2:0]; a_i = a[7:0]; b_i = b[7:0]; cond_i = cond[4:0];
    @(posedge clk);
    model_op(op, a, b);
    @(negedge clk);
    compare_all(tag, cond);
  endtask

  // R13: sweep all codes over held flags, no edge in between.
  task automatic sweep_conds(input string tag);
    op_i = 3'd0;
    for (int k = 0; k < 32; k++) begin
      cond_i = k[4:0];
      #1;
      check(take_o == m_take(k), {req_of(k), " R13 ", tag}, take_o, m_take(k));
    end
  endtask

  // Compare then check magnitude relations numerically (R10, R11).
  task automatic cmp_rel(input int a, input int b);
    int sa, sb;
    sa = sx(a); sb = sx(b);
    step(3, a, b, 0, "R7 cmp");
    op_i = 3'd0;
    cond_i = 5'd8;  #1; check(take_o == (a > b),  "R10 higher", take_o, a > b);
    cond_i = 5'd9;  #1; check(take_o == (a >= b), "R10 higher-eq", take_o, a >= b);
    cond_i = 5'd10; #1; check(take_o == (a < b),  "R10 lower", take_o, a < b);
    cond_i = 5'd11; #1; check(take_o == (a <= b), "R10 lower-eq", take_o, a <= b);
    cond_i = 5'd12; #1; check(take_o == (a == b), "R10 equal", take_o, a == b);
    cond_i = 5'd13; #1; check(take_o == (a != b), "R10 not-equal", take_o, a != b);
    cond_i = 5'd16; #1; check(take_o == (sa > sb),  "R11 greater", take_o, sa > sb);
    cond_i = 5'd17; #1; check(take_o == (sa >= sb), "R11 greater-eq", take_o, sa >= sb);
    cond_i = 5'd18; #1; check(take_o == (sa < sb),  "R11 less", take_o, sa < sb);
    cond_i = 5'd19; #1; check(take_o == (sa <= sb), "R11 less-eq", take_o, sa <= sb);
    cond_i = 5'd20; #1; check(take_o == (sa == sb), "R11 equal", take_o, sa == sb);
    cond_i = 5'd21; #1; check(take_o == (sa != sb), "R11 not-equal", take_o, sa != sb);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_res = 0; m_c = 0; m_s = 0; m_z = 0; m_v = 0;
    op_i = 3'd2; a_i = 8'h55; b_i = 8'h11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R14
    check(res_o == 8'd0 && {c_o, s_o, z_o, v_o} == 4'd0, "R14 reset", {res_o, c_o, s_o, z_o, v_o}, 0);
    op_i = 3'd0;
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R14 after release", 0);

    // R2, R4, R5 subtract corners
    step(2, 8'h05, 8'h03, 2, "R2 sub small");
    step(2, 8'h00, 8'h01, 3, "R2 sub borrow");
    step(2, 8'h80, 8'h01, 6, "R5 sub overflow");
    step(2, 8'h7F, 8'hFF, 6, "R5 sub overflow pos");
    step(2, 8'h42, 8'h42, 0, "R4 sub zero");
    // R3 add corners
    step(1, 8'hFF, 8'h01, 2, "R3 add wrap");
    step(1, 8'h7F, 8'h01, 6, "R5 add overflow");
    step(1, 8'h80, 8'h80, 6, "R5 add neg overflow");
    step(1, 8'h12, 8'h34, 5, "R3 add plain");
    // R6, R7 logic and test
    step(4, 8'hF0, 8'h3C, 5, "R6 and");
    step(5, 8'h0F, 8'hF0, 0, "R7 tst zero");
    step(3, 8'h10, 8'h20, 3, "R7 cmp keeps result");
    // R8 no-op and unused op codes
    step(0, 8'hAA, 8'h55, 1, "R8 nop");
    step(6, 8'h00, 8'h00, 0, "R8 op6");
    step(7, 8'hFF, 8'hFF, 4, "R1 op7");
    sweep_conds("held");

    // magnitude relations
    cmp_rel(8'h05, 8'h03);
    cmp_rel(8'h03, 8'h05);
    cmp_rel(8'h80, 8'h7F);
    cmp_rel(8'h7F, 8'h80);
    cmp_rel(8'hFF, 8'h01);
    cmp_rel(8'h44, 8'h44);
    cmp_rel(8'h00, 8'hFF);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      step($urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 255),
           $urandom_range(0, 31), "R1 random");
    end
    sweep_conds("random end");

    // R14 reset in mid-run
    rst_n = 1'b0;
    @(posedge clk);
    m_res = 0; m_c = 0; m_s = 0; m_z = 0; m_v = 0;
    @(negedge clk);
    check(res_o == 8'd0 && {c_o, s_o, z_o, v_o} == 4'd0, "R14 reset again", {res_o, c_o, s_o, z_o, v_o}, 0);
    rst_n = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule